// File: doc/BRIEF.md
# GPIO Pin Controller with Level Interrupts

This block drives and senses 23 general-purpose pads through a bank of word-addressed control registers. Software writes per-pin control planes (output level, output enable, input buffer enable, pull on/off, pull direction, two drive-strength planes, slew and input type) and a 32-bit alternate-function select word. Every plane is one bit per pin, and bit n always belongs to pin n. Each control bit goes straight out to the pad as a registered output.

Pad levels pass through a two-stage synchronizer. The synchronized levels can be read back, and they also feed eight level-type interrupt lines. Line k follows pin 16+k and is gated by bit k of an interrupt mask word. Line 7 has no pin behind it.

Requests use a valid/ready port that is always ready. A write takes effect at the clock edge that accepts it. A read answers with `rsp_valid` and data one cycle after it is accepted.

Top module: `gpio_pinctrl`

## Requirements
- R1: After reset every register reads zero, and every pad output, the function word and all interrupt lines are low.
- R2: Word index = byte offset / 4: function select 0x00, input enable 0x04, interrupt mask 0x08, input type 0x0C, output level 0x10, output enable 0x14, input sample 0x18, pull enable 0x1C, pull select 0x20, slew 0x24, drive bit 0 0x28, drive bit 1 0x2C. A read returns the stored value with `rsp_valid` high exactly one cycle after the accepted read.
- R3: In per-pin registers bits 23..31 read zero and ignore writes. The function word keeps all 32 bits. The interrupt mask keeps bits 0..7 and reads zero above them.
- R4: `pad_out`, `pad_oe`, `pad_ie`, `pad_slew` and `pad_itype` equal bit n of their registers for pin n from the cycle after the write.
- R5: Pull code 0 means pull enable clear. Code 1 means enable set and select clear (`pad_pull_up`=0). Code 2 means both set. The code read back is 0 when enable is clear, else select plus 1.
- R6: `pad_drive[2n]` is bit n of the 0x28 register and `pad_drive[2n+1]` is bit n of the 0x2C register.
- R7: Reading 0x18 returns the pin levels after a two-flop synchronizer (stable for 3 cycles before the read). Writes to 0x18 change nothing.
- R8: Interrupt k (k < 7) is high while mask bit k is set and the synchronized level of pin 16+k is high, one register later than the synchronizer. A masked line stays low.
- R9: Interrupt line 7 stays low for any mask and pin values.
- R10: Each function-select bit is independent: setting or clearing one bit by read-modify-write leaves the other bits unchanged.
- R11: Word indices 12..15 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word index |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Always high |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 23 | Pad input levels |
| pad_out | output | 23 | Output level per pin |
| pad_oe | output | 23 | Output driver enable |
| pad_ie | output | 23 | Input buffer enable |
| pad_pull_en | output | 23 | Pull resistor on |
| pad_pull_up | output | 23 | Pull direction select |
| pad_drive | output | 46 | Two drive bits per pin |
| pad_slew | output | 23 | Slew control |
| pad_itype | output | 23 | Input type control |
| func_sel | output | 32 | Function select word |
| irq | output | 8 | Level interrupt lines |

## Verification
The hardest situation to reach from the ports is an interrupt that depends on three things at once: the mask bit, the pin level after two synchronizer stages, and the extra register stage. On top of that, line 7 must stay silent when every mask bit and every pin is high.

The stimulus holds random pin patterns for several cycles and interleaves them with random mask writes. It then compares all eight lines against a model that ANDs the mask with pins 16..22. Directed steps also set all mask bits with all pins high, and use a sparse mask to show masking.

// File: rtl/gpio_pinctrl_pkg.sv
package gpio_pinctrl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    IDX_FUNC    = 4'd0,
    IDX_INEN    = 4'd1,
    IDX_IRQMASK = 4'd2,
    IDX_ITYPE   = 4'd3,
    IDX_DOUT    = 4'd4,
    IDX_DOE     = 4'd5,
    IDX_SAMPLE  = 4'd6,
    IDX_PULLEN  = 4'd7,
    IDX_PULLSEL = 4'd8,
    IDX_SLEW    = 4'd9,
    IDX_DRV0    = 4'd10,
    IDX_DRV1    = 4'd11
  } reg_idx_e;
endpackage

// File: rtl/gpio_pinctrl_sync.sv
module gpio_pinctrl_sync #(
  parameter int unsigned WIDTH  = 23,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pinctrl_irq.sv
module gpio_pinctrl_irq #(
  parameter int unsigned NPINS    = 23,
  parameter int unsigned NIRQ     = 8,
  parameter int unsigned IRQ_BASE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_sync,
  input  logic [NIRQ-1:0]  mask_en,
  output logic [NIRQ-1:0]  irq
);
  logic [NIRQ-1:0] hit;

  for (genvar k = 0; k < NIRQ; k++) begin : g_line
    if (IRQ_BASE + k < NPINS) begin : g_pin
      assign hit[k] = mask_en[k] & pin_sync[IRQ_BASE + k];
    end else begin : g_none
      assign hit[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= hit;
  end
endmodule

// File: rtl/gpio_pinctrl_regs.sv
module gpio_pinctrl_regs
  import gpio_pinctrl_pkg::*;
#(
  parameter int unsigned NPINS = 23,
  parameter int unsigned NIRQ  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  sample,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] func_q,
  output logic [NPINS-1:0]  inen_q,
  output logic [NIRQ-1:0]   irqmask_q,
  output logic [NPINS-1:0]  itype_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  doe_q,
  output logic [NPINS-1:0]  pullen_q,
  output logic [NPINS-1:0]  pullsel_q,
  output logic [NPINS-1:0]  slew_q,
  output logic [NPINS-1:0]  drv0_q,
  output logic [NPINS-1:0]  drv1_q
);
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q    <= '0;
      inen_q    <= '0;
      irqmask_q <= '0;
      itype_q   <= '0;
      dout_q    <= '0;
      doe_q     <= '0;
      pullen_q  <= '0;
      pullsel_q <= '0;
      slew_q    <= '0;
      drv0_q    <= '0;
      drv1_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        IDX_FUNC:    func_q    <= wdata;
        IDX_INEN:    inen_q    <= wdata[NPINS-1:0];
        IDX_IRQMASK: irqmask_q <= wdata[NIRQ-1:0];
        IDX_ITYPE:   itype_q   <= wdata[NPINS-1:0];
        IDX_DOUT:    dout_q    <= wdata[NPINS-1:0];
        IDX_DOE:     doe_q     <= wdata[NPINS-1:0];
        IDX_PULLEN:  pullen_q  <= wdata[NPINS-1:0];
        IDX_PULLSEL: pullsel_q <= wdata[NPINS-1:0];
        IDX_SLEW:    slew_q    <= wdata[NPINS-1:0];
        IDX_DRV0:    drv0_q    <= wdata[NPINS-1:0];
        IDX_DRV1:    drv1_q    <= wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      IDX_FUNC:    rd_word                = func_q;
      IDX_INEN:    rd_word[NPINS-1:0]     = inen_q;
      IDX_IRQMASK: rd_word[NIRQ-1:0]      = irqmask_q;
      IDX_ITYPE:   rd_word[NPINS-1:0]     = itype_q;
      IDX_DOUT:    rd_word[NPINS-1:0]     = dout_q;
      IDX_DOE:     rd_word[NPINS-1:0]     = doe_q;
      IDX_SAMPLE:  rd_word[NPINS-1:0]     = sample;
      IDX_PULLEN:  rd_word[NPINS-1:0]     = pullen_q;
      IDX_PULLSEL: rd_word[NPINS-1:0]     = pullsel_q;
      IDX_SLEW:    rd_word[NPINS-1:0]     = slew_q;
      IDX_DRV0:    rd_word[NPINS-1:0]     = drv0_q;
      IDX_DRV1:    rd_word[NPINS-1:0]     = drv1_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/gpio_pinctrl.sv
module gpio_pinctrl
  import gpio_pinctrl_pkg::*;
#(
  parameter int unsigned NPINS       = 23,
  parameter int unsigned NIRQ        = 8,
  parameter int unsigned IRQ_BASE    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_ie,
  output logic [NPINS-1:0]   pad_pull_en,
  output logic [NPINS-1:0]   pad_pull_up,
  output logic [2*NPINS-1:0] pad_drive,
  output logic [NPINS-1:0]   pad_slew,
  output logic [NPINS-1:0]   pad_itype,
  output logic [DATA_W-1:0]  func_sel,
  output logic [NIRQ-1:0]    irq
);
  logic             wr_en;
  logic             rd_en;
  logic [NPINS-1:0] pin_sync;
  logic [NIRQ-1:0]  irqmask_q;
  logic [NPINS-1:0] drv0_q;
  logic [NPINS-1:0] drv1_q;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid & req_write;
  assign rd_en     = req_valid & ~req_write;

  gpio_pinctrl_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_pinctrl_regs #(.NPINS(NPINS), .NIRQ(NIRQ)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .sample    (pin_sync),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .func_q    (func_sel),
    .inen_q    (pad_ie),
    .irqmask_q (irqmask_q),
    .itype_q   (pad_itype),
    .dout_q    (pad_out),
    .doe_q     (pad_oe),
    .pullen_q  (pad_pull_en),
    .pullsel_q (pad_pull_up),
    .slew_q    (pad_slew),
    .drv0_q    (drv0_q),
    .drv1_q    (drv1_q)
  );

  gpio_pinctrl_irq #(.NPINS(NPINS), .NIRQ(NIRQ), .IRQ_BASE(IRQ_BASE)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .pin_sync (pin_sync),
    .mask_en  (irqmask_q),
    .irq      (irq)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_drive
    assign pad_drive[2*n]   = drv0_q[n];
    assign pad_drive[2*n+1] = drv1_q[n];
  end
endmodule

// File: rtl/gpio_pinctrl_chk.sv
module gpio_pinctrl_chk
  import gpio_pinctrl_pkg::*;
#(
  parameter int unsigned NPINS    = 23,
  parameter int unsigned NIRQ     = 8,
  parameter int unsigned IRQ_BASE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NIRQ-1:0]   irq,
  input logic [NIRQ-1:0]   int_en,
  input logic [NPINS-1:0]  pin_sync
);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr) != IDX_FUNC && $past(req_addr) != IDX_IRQMASK)
      |-> rsp_rdata[DATA_W-1:NPINS] == '0);

  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid && req_write) |-> $stable(pad_oe));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (irq & ~$past(int_en)) == '0);

  for (genvar k = 0; k < NIRQ; k++) begin : g_src
    if (IRQ_BASE + k < NPINS) begin : g_pin
      // R8
      irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq[k] |-> $past(pin_sync[IRQ_BASE + k]));
    end
  end
endmodule

bind gpio_pinctrl gpio_pinctrl_chk #(.NPINS(NPINS), .NIRQ(NIRQ), .IRQ_BASE(IRQ_BASE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .int_en    (irqmask_q),
  .pin_sync  (pin_sync)
);

// File: tb/gpio_pinctrl_bench.sv
module gpio_pinctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_ie, pad_pull_en, pad_pull_up, pad_slew, pad_itype;
  logic [2*NP-1:0] pad_drive;
  logic [31:0] func_sel;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinctrl u_gpio_pinctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_drive(pad_drive),
    .pad_slew(pad_slew), .pad_itype(pad_itype), .func_sel(func_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int a);
    if (a == 0) return 32'hFFFF_FFFF;
    if (a == 2) return 32'h0000_00FF;
    if (a == 6 || a >= 12) return 32'h0;
    return 32'h007F_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    if (a == 6) return {9'b0, pin_in};
    return mdl[a];
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] e = '0;
    for (int k = 0; k < 7; k++) e[k] = mdl[2][k] & pin_in[16+k];
    return e;
  endfunction

  function automatic logic [2*NP-1:0] exp_drive();
    logic [2*NP-1:0] d;
    for (int n = 0; n < NP; n++) begin
      d[2*n]   = mdl[10][n];
      d[2*n+1] = mdl[11][n];
    end
    return d;
  endfunction

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    mdl[a] = d & wmask(a);
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R4 R6 R8 R9: pads and interrupt lines against the model
  task automatic check_pads(input string tag);
    chk({tag, " R4 pad_out"},   64'(pad_out),   64'(mdl[4][NP-1:0]));
    chk({tag, " R4 pad_oe"},    64'(pad_oe),    64'(mdl[5][NP-1:0]));
    chk({tag, " R4 pad_ie"},    64'(pad_ie),    64'(mdl[1][NP-1:0]));
    chk({tag, " R4 pad_slew"},  64'(pad_slew),  64'(mdl[9][NP-1:0]));
    chk({tag, " R4 pad_itype"}, 64'(pad_itype), 64'(mdl[3][NP-1:0]));
    chk({tag, " R5 pull_en"},   64'(pad_pull_en), 64'(mdl[7][NP-1:0]));
    chk({tag, " R5 pull_up"},   64'(pad_pull_up), 64'(mdl[8][NP-1:0]));
    chk({tag, " R6 drive"},     64'(pad_drive), 64'(exp_drive()));
    chk({tag, " R10 func"},     64'(func_sel),  64'(mdl[0]));
    wait_cyc(1);
    chk({tag, " R8 R9 irq"},    64'(irq),       64'(exp_irq()));
  endtask

  task automatic set_pull(input int pin, input int code);
    logic [31:0] pe, ps;
    bus_read(7, pe);
    bus_read(8, ps);
    pe[pin] = (code != 0);
    ps[pin] = (code == 2);
    bus_write(7, pe);
    bus_write(8, ps);
  endtask

  task automatic get_pull(input int pin, output int code);
    logic [31:0] pe, ps;
    bus_read(7, pe);
    bus_read(8, ps);
    code = pe[pin] ? (int'(ps[pin]) + 1) : 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int code;
    int seed_init;
    seed_init = int'($urandom(32'h5EED_0017));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 func", 64'(func_sel), 64'd0);
    for (int a = 0; a < 12; a++) begin
      if (a == 6) continue;
      bus_read(a, rd);
      chk("R1 R2 reg reset", 64'(rd), 64'd0);
    end
    check_pads("R1");

    // R3 upper bits of per-pin and mask registers
    bus_write(4, 32'hFFFF_FFFF);
    bus_read(4, rd);
    chk("R3 dout width", 64'(rd), 64'h007F_FFFF);
    bus_write(2, 32'hFFFF_FFFF);
    bus_read(2, rd);
    chk("R3 mask width", 64'(rd), 64'h0000_00FF);
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, rd);
    chk("R3 func width", 64'(rd), 64'hFFFF_FFFF);

    // R9 all masks, all pins high: line 7 stays low
    pin_in = '1;
    wait_cyc(4);
    chk("R9 line7 low", 64'(irq), 64'h7F);
    // R8 sparse mask
    bus_write(2, 32'h0000_0005);
    wait_cyc(1);
    chk("R8 sparse mask", 64'(irq), 64'h05);
    pin_in = '0;
    wait_cyc(4);
    chk("R8 pins low", 64'(irq), 64'h00);

    // R7 sample reads pins and ignores writes
    pin_in = 23'h5A_3C_96;
    wait_cyc(3);
    bus_write(6, 32'hFFFF_FFFF);
    bus_read(6, rd);
    chk("R7 sample", 64'(rd), 64'(pin_in));

    // R10 function bits via read-modify-write
    bus_write(0, 32'h0);
    bus_read(0, rd); bus_write(0, rd | 32'h8);
    bus_read(0, rd); bus_write(0, rd | 32'h4000_0000);
    bus_read(0, rd); bus_write(0, rd & ~32'h8);
    bus_read(0, rd);
    chk("R10 func rmw", 64'(rd), 64'h4000_0000);
    chk("R10 func port", 64'(func_sel), 64'h4000_0000);

    // R5 pull codes
    for (int c = 0; c < 3; c++) begin
      set_pull(9, c);
      get_pull(9, code);
      chk("R5 pull code", 64'(code), 64'(c));
      chk("R5 pull_en pin9", 64'(pad_pull_en[9]), 64'(c != 0));
      chk("R5 pull_up pin9", 64'(pad_pull_up[9]), 64'(c == 2));
    end

    // R6 drive planes
    bus_write(10, 32'h0000_0020);
    bus_write(11, 32'h0000_0020);
    chk("R6 pin5 drive", 64'(pad_drive[11:10]), 64'd3);
    bus_write(11, 32'h0);
    chk("R6 pin5 drive low bit", 64'(pad_drive[11:10]), 64'd1);

    // R11 unmapped indices
    for (int a = 12; a < 16; a++) begin
      bus_write(a, 32'hFFFF_FFFF);
      bus_read(a, rd);
      chk("R11 unmapped", 64'(rd), 64'd0);
    end
    check_pads("R11 after");

    // Random traffic
    for (int it = 0; it < 60; it++) begin
      int a;
      pin_in = NP'($urandom);
      a = int'($urandom_range(0, 15));
      bus_write(a, $urandom);
      if (it % 3 == 0) bus_write(2, $urandom);
      wait_cyc(3);
      check_pads("RND");
      for (int r = 0; r < 16; r++) begin
        bus_read(r, rd);
        chk("R2 R3 R7 R11 random read", 64'(rd), 64'(exp_read(r)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule